// File: doc/BRIEF.md
# Flash Page Program and Erase Array Engine

This block models the byte-wide storage array behind a serial non-volatile memory, and the program and erase operations on it. A controller that has already decoded the serial commands and applied the protection policy opens a page program session with a start address. It then streams data bytes into the session and closes it. It can also request the erase of one sector or of the whole array. Programming can only clear bits, so each stored byte becomes the old value ANDed with the incoming byte. Erasing returns bytes to FFh. The array has two sectors, and the top address bit selects between them. A page is `2**PAGE_W` bytes, and the byte address inside one program session wraps within its page. It never moves into the next page.

After every accepted operation, a busy flag stays high for a fixed number of system clocks, so that software can poll for completion. Each operation kind has its own length parameter. The array contents change when the operation is accepted or when the byte arrives, and the busy window only models the internal cycle time. A simple registered read port returns the byte at any address one clock after the address is presented. The array size is a parameter: the default is 2 KiB (two sectors of four 256-byte pages). Setting `ADDR_W` to 16 gives two sectors of 128 pages each.

Top module: `flpe_engine`

## Requirements
- R1: After reset, `busy` is low and no program session is open, so data bytes and session ends that arrive before any program request change no byte and start no busy window.
- R2: A data byte written in a session replaces the stored byte with (stored AND data). A bit that is 0 never returns to 1 through programming.
- R3: The first byte of a session goes to the start address. Each further byte goes to the next column of the same page, and after the last column of the page it wraps to column 0 of that page. The page bits never change during a session.
- R4: A sector erase (`cmd_op` = 2'b01) sets every byte whose top address bit equals the top bit of `cmd_addr` to FFh, and leaves the other sector unchanged.
- R5: A bulk erase (`cmd_op` = 2'b10) sets every byte of the array to FFh.
- R6: `busy` rises on the clock edge that closes a non-empty program session or accepts an erase. It then stays high for exactly `T_PROG`, `T_SE` or `T_BE` clock cycles, for program, sector erase and bulk erase.
- R7: A request with `cmd_valid` high is ignored while `busy` is high or while a program session is open. `cmd_op` = 2'b00 opens a program session, and 2'b11 is ignored.
- R8: A session closed before any data byte arrived changes no byte and leaves `busy` low.
- R9: `rd_data` shows the byte stored at `rd_addr` one clock cycle after `rd_addr` is presented.
- R10: A data byte that arrives in the same cycle as the session end is written before the session closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Request strobe for a program or erase |
| cmd_op | input | 2 | 00 program, 01 sector erase, 10 bulk erase, 11 none |
| cmd_addr | input | ADDR_W | Start address for a program, sector select (top bit) for a sector erase |
| data_valid | input | 1 | A program data byte is present |
| data_byte | input | 8 | Program data byte |
| data_end | input | 1 | Closes the open program session |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Byte at the read address of the previous cycle |
| busy | output | 1 | Internal program or erase cycle in progress |

## Verification
Two functions can fall in the same cycle. The last data byte of a session can coincide with the session end, and an erase request can arrive in the cycle that closes a program session. The bench provokes both at once. It drives the final byte of a page-wrapping stream together with `data_end` and a sector-erase request. It then reads back that the final byte landed at the wrapped column and that the other sector still holds its programmed bytes. It also measures that the busy window that follows has the program length and not the erase length.

// File: rtl/flpe_pkg.sv
// Shared definitions for the flash program/erase engine.
// Assumes: the command encoding is fixed at two bits.
package flpe_pkg;
    typedef enum logic [1:0] {
        OP_PROG = 2'b00,
        OP_SECT = 2'b01,
        OP_BULK = 2'b10,
        OP_NONE = 2'b11
    } flpe_op_e;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/flpe_timer.sv
// Busy window generator: once started, it holds busy high for exactly LEN
// clocks, where LEN is the value given with the start pulse.
// Assumes: start is never pulsed while busy is high, and len is at least 1.
module flpe_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] len,
    output logic          busy
);
    logic [CW-1:0] remain;

    // Load the remaining count on start, count down while busy, drop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            remain <= len - CW'(1);
        end else if (busy) begin
            if (remain == '0) busy <= 1'b0;
            else              remain <= remain - CW'(1);
        end
    end

    // R6: the window does not close early while cycles remain.
    a_r6_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && remain != '0 && !start) |=> busy);

    // R6: busy only rises as a result of a start pulse.
    a_r6_rise_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

// File: rtl/flpe_array.sv
// Byte storage with flash semantics: a write ANDs its data into the stored
// byte, and an erase sets a whole sector or the whole array to FFh. The read
// port is registered. Contents are not cleared by reset (non-volatile).
// Assumes: erase and write strobes never occur in the same cycle.
module flpe_array #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              se_en,
    input  logic              se_hi,
    input  logic              be_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int SECT_BYTES = DEPTH / 2;

    logic [7:0] mem [DEPTH];

    // Per-byte update: erase to all ones, otherwise AND in program data.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (be_en || (se_en && ((i >= SECT_BYTES) == se_hi)))
                mem[i] <= 8'hFF;
            else if (wr_en && wr_addr == ADDR_W'(i))
                mem[i] <= mem[i] & wr_data;
        end
    end

    // Registered read of the addressed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= 8'h00;
        else        rd_data <= mem[rd_addr];
    end

    // R2: a program write never turns a 0 bit into a 1.
    a_r2_no_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !se_en && !be_en) |=>
        ((mem[$past(wr_addr)] & ~$past(mem[wr_addr])) == 8'h00));

    // R5: after a bulk erase both ends of the array read FFh.
    a_r5_bulk_ends: assert property (@(posedge clk) disable iff (!rst_n)
        be_en |=> (mem[0] == 8'hFF && mem[DEPTH-1] == 8'hFF));
endmodule

// File: rtl/flpe_ctrl.sv
// Operation control: accepts requests when idle, keeps the program session
// and its in-page byte address, and issues write/erase strobes and busy
// window starts with the length of the operation.
// Assumes: busy comes from the timer driven by tmr_start/tmr_len.
module flpe_ctrl
    import flpe_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 8,
    parameter int CW     = 8,
    parameter int T_PROG = 4,
    parameter int T_SE   = 8,
    parameter int T_BE   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  flpe_op_e          cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              data_valid,
    input  logic [7:0]        data_byte,
    input  logic              data_end,
    input  logic              busy,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              se_en,
    output logic              se_hi,
    output logic              be_en,
    output logic              tmr_start,
    output logic [CW-1:0]     tmr_len
);
    localparam int PG_BITS = ADDR_W - PAGE_W;

    logic              open_q;
    logic              got_q;
    logic [PG_BITS-1:0] page_q;
    logic [PAGE_W-1:0]  col_q;
    logic              accept;
    logic              prog_start;
    logic              closing;

    // Request acceptance and strobe decode.
    always_comb begin
        accept     = cmd_valid && !busy && !open_q;
        prog_start = accept && (cmd_op == OP_PROG);
        se_en      = accept && (cmd_op == OP_SECT);
        be_en      = accept && (cmd_op == OP_BULK);
        se_hi      = cmd_addr[ADDR_W-1];
        wr_en      = open_q && data_valid;
        wr_addr    = {page_q, col_q};
        wr_data    = data_byte;
        closing    = open_q && data_end;
    end

    // Busy window start and length selection.
    always_comb begin
        tmr_start = 1'b0;
        tmr_len   = CW'(T_PROG);
        if (closing && (got_q || data_valid)) begin
            tmr_start = 1'b1;
            tmr_len   = CW'(T_PROG);
        end else if (se_en) begin
            tmr_start = 1'b1;
            tmr_len   = CW'(T_SE);
        end else if (be_en) begin
            tmr_start = 1'b1;
            tmr_len   = CW'(T_BE);
        end
    end

    // Session state: open flag, byte seen flag, page and wrapping column.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            got_q  <= 1'b0;
            page_q <= '0;
            col_q  <= '0;
        end else if (prog_start) begin
            open_q <= 1'b1;
            got_q  <= 1'b0;
            page_q <= cmd_addr[ADDR_W-1:PAGE_W];
            col_q  <= cmd_addr[PAGE_W-1:0];
        end else if (open_q) begin
            if (wr_en) begin
                got_q <= 1'b1;
                col_q <= col_q + PAGE_W'(1);
            end
            if (data_end) open_q <= 1'b0;
        end
    end

    // R3: the page of the write pointer stays fixed across session writes.
    a_r3_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !data_end) |=> (page_q == $past(page_q)));

    // R7: at most one array operation is issued per cycle.
    a_r7_one_op: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, se_en, be_en, prog_start}));

    // R8: an empty session close starts no busy window.
    a_r8_empty_close: assert property (@(posedge clk) disable iff (!rst_n)
        (closing && !got_q && !data_valid) |=> !busy);
endmodule

// File: rtl/flpe_engine.sv
// Top of the flash program/erase engine: control, busy timer and array.
// Assumes: ADDR_W > PAGE_W, and every busy length parameter is at least 1.
module flpe_engine
    import flpe_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 8,
    parameter int T_PROG = 64,
    parameter int T_SE   = 256,
    parameter int T_BE   = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              data_valid,
    input  logic [7:0]        data_byte,
    input  logic              data_end,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy
);
    localparam int T_MAX1 = (T_PROG > T_SE) ? T_PROG : T_SE;
    localparam int T_MAX  = (T_MAX1 > T_BE) ? T_MAX1 : T_BE;
    localparam int CW     = $clog2(T_MAX + 1);

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic              se_en;
    logic              se_hi;
    logic              be_en;
    logic              tmr_start;
    logic [CW-1:0]     tmr_len;

    flpe_ctrl #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CW(CW),
        .T_PROG(T_PROG), .T_SE(T_SE), .T_BE(T_BE)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(flpe_op_e'(cmd_op)), .cmd_addr(cmd_addr),
        .data_valid(data_valid), .data_byte(data_byte), .data_end(data_end),
        .busy(busy),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .se_en(se_en), .se_hi(se_hi), .be_en(be_en),
        .tmr_start(tmr_start), .tmr_len(tmr_len)
    );

    flpe_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .start(tmr_start), .len(tmr_len), .busy(busy)
    );

    flpe_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .se_en(se_en), .se_hi(se_hi), .be_en(be_en),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // R7: no erase strobe reaches the array while busy is high.
    a_r7_no_erase_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(se_en || be_en));
endmodule

// File: tb/flpe_engine_test.sv
// Self-checking bench for flpe_engine with shortened busy windows.
module flpe_engine_test;
    localparam int AW  = 11;
    localparam int TP  = 5;
    localparam int TS  = 7;
    localparam int TB  = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'b11;
    logic [AW-1:0] cmd_addr = '0;
    logic          data_valid = 1'b0;
    logic [7:0]    data_byte = 8'h00;
    logic          data_end = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    flpe_engine #(.ADDR_W(AW), .PAGE_W(8), .T_PROG(TP), .T_SE(TS), .T_BE(TB)) uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .data_valid(data_valid), .data_byte(data_byte), .data_end(data_end),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );

    // {address, program byte, expected read-back} on a freshly erased array.
    localparam logic [26:0] VEC [8] = '{
        {11'h010, 8'hA5, 8'hA5},
        {11'h010, 8'h3C, 8'h24},
        {11'h010, 8'hFF, 8'h24},
        {11'h2FF, 8'h0F, 8'h0F},
        {11'h400, 8'h81, 8'h81},
        {11'h7FF, 8'h00, 8'h00},
        {11'h000, 8'hFE, 8'hFE},
        {11'h000, 8'h7F, 8'h7E}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cmd(input logic [1:0] op, input logic [AW-1:0] a);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b11;
    endtask

    task automatic busy_len(input string tag, input int exp);
        int n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
        check(tag, n, exp);
    endtask

    task automatic rd(input string tag, input logic [AW-1:0] a, input logic [7:0] exp);
        @(negedge clk);
        rd_addr = a;
        @(negedge clk);
        check(tag, rd_data, exp);
    endtask

    task automatic prog1(input logic [AW-1:0] a, input logic [7:0] d);
        cmd(2'b00, a);
        data_valid = 1'b1; data_byte = d; data_end = 1'b1;
        @(negedge clk);
        data_valid = 1'b0; data_end = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 busy after reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5/R6: bulk erase then window length
        cmd(2'b10, '0);
        busy_len("R6 bulk erase window", TB);
        rd("R5 bulk erase low end", 11'h000, 8'hFF);
        rd("R5 bulk erase high end", 11'h7FF, 8'hFF);

        // R1: data and end without a session
        @(negedge clk);
        data_valid = 1'b1; data_byte = 8'h00; data_end = 1'b1;
        @(negedge clk);
        data_valid = 1'b0; data_end = 1'b0;
        check("R1 no busy without session", busy, 0);
        rd("R1 byte kept without session", 11'h000, 8'hFF);

        // R2/R9: vector table of single-byte programs
        for (int k = 0; k < 8; k++) begin
            prog1(VEC[k][26:16], VEC[k][15:8]);
            busy_len("R6 program window", TP);
            rd("R2 R9 AND program read-back", VEC[k][26:16], VEC[k][7:0]);
        end

        // R8: empty session
        cmd(2'b00, 11'h123);
        data_end = 1'b1;
        @(negedge clk);
        data_end = 1'b0;
        check("R8 empty session busy", busy, 0);
        rd("R8 empty session byte", 11'h123, 8'hFF);

        // R3/R10/R7: wrapping stream, last byte with end and an erase request
        cmd(2'b00, 11'h1FE);
        for (int k = 0; k < 4; k++) begin
            data_valid = 1'b1; data_byte = 8'h11 * (k + 1);
            if (k == 3) begin
                data_end = 1'b1; cmd_valid = 1'b1; cmd_op = 2'b01; cmd_addr = 11'h400;
            end
            @(negedge clk);
        end
        data_valid = 1'b0; data_end = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b11;
        busy_len("R7 R6 program window not erase", TP);
        rd("R3 column FE", 11'h1FE, 8'h11);
        rd("R3 column FF", 11'h1FF, 8'h22);
        rd("R3 wrap to column 0", 11'h100, 8'h33);
        rd("R10 last byte with end", 11'h101, 8'h44);
        rd("R3 next page untouched", 11'h200, 8'hFF);
        rd("R7 erase during close ignored", 11'h400, 8'h81);

        // R4: sector erase of upper half, lower half kept
        cmd(2'b01, 11'h5AB);
        busy_len("R6 sector erase window", TS);
        rd("R4 upper sector erased", 11'h400, 8'hFF);
        rd("R4 upper sector top erased", 11'h7FF, 8'hFF);
        rd("R4 lower sector kept", 11'h010, 8'h24);

        // R7: requests while busy are ignored
        prog1(11'h400, 8'h00);
        busy_len("R6 program window", TP);
        cmd(2'b01, 11'h000);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b10;
        @(negedge clk);
        cmd_op = 2'b00; cmd_addr = 11'h600;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b11;
        busy_len("R7 window not extended", TS - 3);
        rd("R7 bulk erase while busy ignored", 11'h400, 8'h00);
        rd("R4 lower sector erased", 11'h010, 8'hFF);
        data_valid = 1'b1; data_byte = 8'h00; data_end = 1'b1;
        @(negedge clk);
        data_valid = 1'b0; data_end = 1'b0;
        rd("R7 program while busy ignored", 11'h600, 8'hFF);

        // R7: reserved op ignored
        cmd(2'b11, 11'h400);
        check("R7 reserved op no busy", busy, 0);
        rd("R7 reserved op no change", 11'h400, 8'h00);

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected done", cyc);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule